// File: doc/BRIEF.md
# Mode-Selectable Binary/Gray Counter

This block is a synchronous 3-bit counter. Its stored state code is also its output. A one-bit sequence select picks, on every clock edge, which order the counter steps through. With the select low the code advances in plain binary order. With it high the code advances in reflected Gray order, where neighbouring codes differ in exactly one bit.

The select may change at any time. On each enabled edge the counter takes the successor of its present code in whichever order is selected at that edge. The output comes straight from the state register, so it only moves on a rising clock edge. The block suits a controller that wants a glitch-free step counter in one order or the other.

Top module: `mode_seq_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the code becomes 000 on that edge, whatever `cnt_en` and `seq_sel` are.
- R2: With `seq_sel` = 0 and `cnt_en` = 1, each edge sets the code to the present code plus one, modulo 8, so 111 is followed by 000.
- R3: With `seq_sel` = 1 and `cnt_en` = 1, each edge steps through the cycle 000, 001, 011, 010, 110, 111, 101, 100 and then back to 000. Each step changes exactly one bit.
- R4: With `cnt_en` = 0 (and `rst_n` high), the code holds its value across the edge.
- R5: When `seq_sel` changes mid-count, the next code is the successor of the present code in the newly selected order. For example, 011 goes to 010 with `seq_sel` = 1 and to 100 with `seq_sel` = 0.
- R6: The output is registered. A change of `seq_sel` or `cnt_en` between edges leaves `code_q` unchanged until the next rising edge.
- R7: All eight codes are legal states with a defined successor in both orders, so no code can trap the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Advance the code on this edge when high |
| seq_sel | input | 1 | Order select: 0 binary, 1 reflected Gray |
| code_q | output | 3 | Present state code, which is the counter output |

## Verification
The hardest situation to reach is a change of order from every one of the eight codes. Stepping through one order from reset only ever switches order at the few codes where that order happens to be. The bench therefore walks a table of mixed-order steps that crosses between the two orders at many different codes, including the codes at the ends of each order. It then runs a long stretch where the select and the enable are drawn at random on each cycle, and checks every result against its own successor tables.

// File: rtl/seq_cnt_pkg.sv
// Package: shared types for the mode-selectable counter.
// Assumes: a one-bit order select; value 1 selects reflected Gray order.
package seq_cnt_pkg;
    typedef enum logic {
        SEQ_BINARY    = 1'b0,
        SEQ_REFLECTED = 1'b1
    } seq_mode_e;
endpackage

// File: rtl/gray_to_bin.sv
// gray_to_bin: converts a reflected Gray code to its binary rank.
// Assumes: pure combinational; bit i of the rank is the XOR of Gray bits i and above.
module gray_to_bin #(
    parameter int W = 3
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    // Each rank bit is the parity of the Gray bits from its position upward.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin_o[i] = ^gray_i[W-1:i];
    end
endmodule

// File: rtl/bin_to_gray.sv
// bin_to_gray: converts a binary rank to its reflected Gray code.
// Assumes: pure combinational.
module bin_to_gray #(
    parameter int W = 3
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_o
);
    // Each Gray bit is the XOR of a rank bit and the bit above it.
    assign gray_o = bin_i ^ (bin_i >> 1);
endmodule

// File: rtl/code_successor.sv
// code_successor: gives the next code of the present code in the selected order.
// Assumes: both orders cover all 2**W codes; one shared incrementer serves both.
module code_successor
    import seq_cnt_pkg::*;
#(
    parameter int W = 3
) (
    input  logic [W-1:0] cur_i,
    input  seq_mode_e    mode_i,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] rank_from_gray;
    logic [W-1:0] rank_cur;
    logic [W-1:0] rank_nxt;
    logic [W-1:0] gray_nxt;

    gray_to_bin #(.W(W)) u_g2b (.gray_i(cur_i), .bin_o(rank_from_gray));

    // Pick the position of the present code within the selected order.
    assign rank_cur = (mode_i == SEQ_REFLECTED) ? rank_from_gray : cur_i;
    // Advance the position by one, wrapping at the end of the order.
    assign rank_nxt = rank_cur + W'(1);

    bin_to_gray #(.W(W)) u_b2g (.bin_i(rank_nxt), .gray_o(gray_nxt));

    // Map the new position back to a code in the selected order.
    assign nxt_o = (mode_i == SEQ_REFLECTED) ? gray_nxt : rank_nxt;

    // Gray successor must differ from the present code in exactly one bit (R3).
    always_comb begin
        if (mode_i == SEQ_REFLECTED) begin
            p_gray_one_bit_r3: assert ($countones(nxt_o ^ cur_i) == 1);
        end
    end
endmodule

// File: rtl/mode_seq_counter.sv
// mode_seq_counter: 3-bit counter that steps in binary or reflected Gray order.
// Assumes: seq_sel and cnt_en are synchronous to clk; rst_n is a synchronous
// active-low reset; code_q comes straight from the state register.
module mode_seq_counter
    import seq_cnt_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         seq_sel,
    output logic [W-1:0] code_q
);
    localparam logic [W-1:0] CODE_ZERO = '0;
    localparam logic [W-1:0] GRAY_LAST = W'(1) << (W - 1);

    seq_mode_e    mode;
    logic [W-1:0] code_nxt;

    assign mode = seq_mode_e'(seq_sel);

    code_successor #(.W(W)) u_succ (
        .cur_i  (code_q),
        .mode_i (mode),
        .nxt_o  (code_nxt)
    );

    // State register: reset to zero, else advance when enabled, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_ZERO;
        end else if (cnt_en) begin
            code_q <= code_nxt;
        end
    end

    // Disabled counter keeps its code (R4).
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(code_q));

    // Binary step adds one modulo the code space (R2).
    p_binary_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !seq_sel) |=> (code_q == W'($past(code_q) + W'(1))));

    // Gray step flips exactly one bit of the registered code (R3).
    p_gray_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && seq_sel) |=> ($countones(code_q ^ $past(code_q)) == 1));

    // Last Gray code wraps to zero (R3).
    p_gray_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && seq_sel && code_q == GRAY_LAST) |=> (code_q == CODE_ZERO));
endmodule

// File: tb/tb_mode_seq_counter.sv
module tb_mode_seq_counter;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 33;
    localparam int NRAND = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       seq_sel = 1'b0;
    logic [2:0] code_q;

    int checks = 0;
    int failures = 0;

    // Vector: {cnt_en, seq_sel, expected code after the edge}, walked from 000.
    localparam logic [4:0] VEC [0:NVEC-1] = '{
        // R2: full binary cycle with wrap
        5'b10_001, 5'b10_010, 5'b10_011, 5'b10_100,
        5'b10_101, 5'b10_110, 5'b10_111, 5'b10_000,
        // R3: full Gray cycle with wrap
        5'b11_001, 5'b11_011, 5'b11_010, 5'b11_110,
        5'b11_111, 5'b11_101, 5'b11_100, 5'b11_000,
        // R5/R4: order changes at many codes, one hold
        5'b10_001, 5'b10_010, 5'b10_011, 5'b11_010,
        5'b10_011, 5'b11_010, 5'b11_110, 5'b01_110,
        5'b10_111, 5'b11_101, 5'b10_110, 5'b11_111,
        5'b11_101, 5'b11_100, 5'b10_101, 5'b11_100,
        5'b11_000
    };

    localparam logic [2:0] GRAY_ORDER [0:7] = '{
        3'b000, 3'b001, 3'b011, 3'b010, 3'b110, 3'b111, 3'b101, 3'b100
    };

    mode_seq_counter dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .seq_sel (seq_sel),
        .code_q  (code_q)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [2:0] ref_next(input logic [2:0] cur, input logic sel);
        logic [2:0] r;
        r = cur + 3'd1;
        if (sel) begin
            for (int k = 0; k < 8; k++) begin
                if (GRAY_ORDER[k] == cur) r = GRAY_ORDER[(k + 1) % 8];
            end
        end
        return r;
    endfunction

    task automatic check(input logic [2:0] exp, input string req);
        checks++;
        if (code_q !== exp) begin
            failures++;
            $display("FAIL %s: code_q=%b expected=%b", req, code_q, exp);
        end
    endtask

    task automatic step(input logic en, input logic sel);
        cnt_en = en;
        seq_sel = sel;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [2:0] model;
        // R1: reset with enable high forces 000
        cnt_en = 1'b1;
        seq_sel = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        step(1'b1, 1'b1);
        check(3'b000, "R1 reset state");
        rst_n = 1'b1;

        // R2 R3 R4 R5 R7: table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][4], VEC[i][3]);
            check(VEC[i][2:0], $sformatf("R2/R3/R4/R5 vector %0d", i));
        end

        // R6: inputs toggled between edges leave the output alone
        step(1'b1, 1'b0);
        check(3'b001, "R6 setup");
        seq_sel = 1'b1;
        #1;
        check(3'b001, "R6 select toggle between edges");
        cnt_en = 1'b0;
        #1;
        seq_sel = 1'b0;
        #1;
        check(3'b001, "R6 enable toggle between edges");

        // R1: reset mid-count beats enable
        step(1'b1, 1'b0);
        check(3'b010, "R1 pre-reset");
        rst_n = 1'b0;
        step(1'b1, 1'b1);
        check(3'b000, "R1 reset mid-count");
        rst_n = 1'b1;

        // R5 R7: random order and enable against reference tables
        model = 3'b000;
        for (int n = 0; n < NRAND; n++) begin
            logic en_r;
            logic sel_r;
            en_r = ($urandom % 4) != 0;
            sel_r = $urandom % 2;
            step(en_r, sel_r);
            if (en_r) model = ref_next(model, sel_r);
            check(model, "R5/R7 random order");
        end

        // R4: long hold at the last Gray code
        step(1'b1, 1'b1);
        model = ref_next(model, 1'b1);
        while (model != 3'b100) begin
            step(1'b1, 1'b1);
            model = ref_next(model, 1'b1);
        end
        check(3'b100, "R4 reach 100");
        for (int h = 0; h < 3; h++) begin
            step(1'b0, 1'b0);
            check(3'b100, "R4 hold");
        end
        step(1'b1, 1'b0);
        check(3'b101, "R5 binary successor of 100");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule